// File: doc/BRIEF.md
# Synthesizer Divider and Phase-Frequency Detector Core

This block is the digital part of an integer-N frequency synthesizer. It takes two enable strobes that run in a single system clock domain. One stands for the voltage-controlled oscillator clock and the other for the crystal clock. The oscillator strobe passes through a fixed divide-by-4 prescaler and then through a programmable main counter. The crystal strobe passes through a programmable reference counter and then through a fixed divide-by-2. The two divided edge pulses feed a tri-state phase-frequency detector. Its separate up and down outputs steer an external charge pump.

The surrounding loop writes the feedback ratio and the reference ratio. Together they set the comparison frequency, and so the tuning step seen at the oscillator output. A ratio outside its legal window is forced to the nearest limit. A ratio change is picked up only when the counter reaches its terminal count, so no divided period is ever cut short.

Top module: `synth_pfd_core`

## Requirements
- R1: While reset is held and directly after it, up_o, dn_o, fb_edge_o and ref_edge_o are all 0.
- R2: With vco_en_i high every cycle and a main ratio N in 128..2600, fb_edge_o is a one-cycle pulse that repeats every 4*N cycles.
- R3: A main ratio below 128 acts as 128, and a ratio above 2600 acts as 2600 (feedback period 512 and 10400 cycles).
- R4: With xtal_en_i high every cycle and a reference ratio R in 2..80, ref_edge_o is a one-cycle pulse that repeats every 2*R cycles.
- R5: A reference ratio below 2 acts as 2, and a ratio above 80 acts as 80 (reference period 4 and 160 cycles).
- R6: The main ratio is sampled only at the main counter's terminal count, which is the cycle that produces fb_edge_o. If the ratio changes just after an fb_edge_o pulse, the next period still uses the old ratio and the one after it uses the new ratio.
- R7: up_o rises in the cycle after a ref_edge_o pulse, and dn_o rises in the cycle after an fb_edge_o pulse. From an idle state, up_o rises on the third cycle after a single crystal strobe. Each output stays high until the other side's edge arrives.
- R8: When up_o and dn_o are both high, both go low together in the next cycle.
- R9: A ref_edge_o and an fb_edge_o in the same cycle make up_o and dn_o high together for exactly one cycle. After that, both stay low.
- R10: Without enable strobes the dividers do not advance, and no edge pulse appears on either path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vco_en_i | input | 1 | One strobe per oscillator clock period |
| xtal_en_i | input | 1 | One strobe per crystal clock period |
| main_ratio_i | input | 12 | Feedback counter ratio, legal range 128..2600 |
| ref_ratio_i | input | 8 | Reference counter ratio, legal range 2..80 |
| up_o | output | 1 | Charge-pump up request |
| dn_o | output | 1 | Charge-pump down request |
| fb_edge_o | output | 1 | One-cycle pulse per divided feedback period |
| ref_edge_o | output | 1 | One-cycle pulse per divided reference period |

## Verification
The bench builds the block with its default parameters: a prescaler of 4, a 12-bit main ratio clamped to 128..2600, and an 8-bit reference ratio clamped to 2..80. These values keep even the longest feedback period of 10400 cycles well inside the run, so both clamp limits of both counters can be timed exactly. Because the strobes are held high every cycle, period lengths follow directly from the ratios. Single strobes after a reset line up the two paths, which makes it possible to force coincident edges and to place a lone up or down request with exact cycle counts.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int unsigned MAIN_W_D   = 12;
  localparam int unsigned MAIN_MIN_D = 128;
  localparam int unsigned MAIN_MAX_D = 2600;
  localparam int unsigned REF_W_D    = 8;
  localparam int unsigned REF_MIN_D  = 2;
  localparam int unsigned REF_MAX_D  = 80;
  localparam int unsigned PRESCALE_D = 4;
  localparam int unsigned POSTDIV_D  = 2;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;
endpackage

// File: rtl/fixed_div.sv
module fixed_div #(
  parameter int unsigned N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic pulse_o
);
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] cnt_q;

  // first strobe after reset fires at once, then every N strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= en_i && (cnt_q == '0);
      if (en_i) cnt_q <= (cnt_q == '0) ? CW'(N - 1) : cnt_q - CW'(1);
    end
  end

  assert_fix_needs_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(en_i));
  assert_fix_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/ratio_div.sv
module ratio_div #(
  parameter int unsigned W   = 12,
  parameter int unsigned MIN = 128,
  parameter int unsigned MAX = 2600
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o
);
  localparam int unsigned CW = $clog2(MAX + 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] clamp_f(logic [W-1:0] r);
    if (r < W'(MIN)) return CW'(MIN);
    if (r > W'(MAX)) return CW'(MAX);
    return CW'(r);
  endfunction

  // ratio is sampled only at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= en_i && (cnt_q == '0);
      if (en_i) cnt_q <= (cnt_q == '0) ? clamp_f(ratio_i) - CW'(1) : cnt_q - CW'(1);
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX - 1));
  assert_div_needs_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(en_i));
  assert_div_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/pfd.sv
module pfd
  import synth_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ref_i,
  input  logic      fb_i,
  output pump_req_t req_o
);
  pump_req_t req_q;

  // clearing dominates over a new edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
    end else if (req_q.up && req_q.dn) begin
      req_q <= '0;
    end else begin
      req_q.up <= req_q.up | ref_i;
      req_q.dn <= req_q.dn | fb_i;
    end
  end

  assign req_o = req_q;

  assert_both_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q.up && req_q.dn) |=> (!req_q.up && !req_q.dn));
  assert_up_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q.up) |-> $past(ref_i));
  assert_dn_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q.dn) |-> $past(fb_i));
endmodule

// File: rtl/synth_pfd_core.sv
module synth_pfd_core
  import synth_pkg::*;
#(
  parameter int unsigned MAIN_W   = MAIN_W_D,
  parameter int unsigned MAIN_MIN = MAIN_MIN_D,
  parameter int unsigned MAIN_MAX = MAIN_MAX_D,
  parameter int unsigned REF_W    = REF_W_D,
  parameter int unsigned REF_MIN  = REF_MIN_D,
  parameter int unsigned REF_MAX  = REF_MAX_D,
  parameter int unsigned PRESCALE = PRESCALE_D,
  parameter int unsigned POSTDIV  = POSTDIV_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vco_en_i,
  input  logic              xtal_en_i,
  input  logic [MAIN_W-1:0] main_ratio_i,
  input  logic [REF_W-1:0]  ref_ratio_i,
  output logic              up_o,
  output logic              dn_o,
  output logic              fb_edge_o,
  output logic              ref_edge_o
);
  logic      pre_p;
  logic      refdiv_p;
  pump_req_t req;

  fixed_div #(.N(PRESCALE)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(vco_en_i), .pulse_o(pre_p));

  ratio_div #(.W(MAIN_W), .MIN(MAIN_MIN), .MAX(MAIN_MAX)) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pre_p), .ratio_i(main_ratio_i),
    .pulse_o(fb_edge_o));

  ratio_div #(.W(REF_W), .MIN(REF_MIN), .MAX(REF_MAX)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(xtal_en_i), .ratio_i(ref_ratio_i),
    .pulse_o(refdiv_p));

  fixed_div #(.N(POSTDIV)) u_post (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(refdiv_p), .pulse_o(ref_edge_o));

  pfd u_pfd (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_edge_o), .fb_i(fb_edge_o),
    .req_o(req));

  assign up_o = req.up;
  assign dn_o = req.dn;

  assert_coincide_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_edge_o && fb_edge_o && !up_o && !dn_o) |=> (up_o && dn_o));
endmodule

// File: tb/synth_pfd_core_bench.sv
module synth_pfd_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vco_en = 1'b0;
  logic        xtal_en = 1'b0;
  logic [11:0] main_ratio = 12'd200;
  logic [7:0]  ref_ratio = 8'd10;
  logic        up, dn, fb_edge, ref_edge;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  synth_pfd_core u_synth_pfd_core (
    .clk_i(clk), .rst_ni(rst_n), .vco_en_i(vco_en), .xtal_en_i(xtal_en),
    .main_ratio_i(main_ratio), .ref_ratio_i(ref_ratio),
    .up_o(up), .dn_o(dn), .fb_edge_o(fb_edge), .ref_edge_o(ref_edge));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vco_en = 1'b0; xtal_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic sel(input bit use_fb);
    return use_fb ? fb_edge : ref_edge;
  endfunction

  task automatic sync_edge(input bit use_fb);
    int n = 0;
    do begin @(negedge clk); n++; end while (!sel(use_fb) && n < 20000);
  endtask

  task automatic count_to_edge(input bit use_fb, output int p);
    p = 0;
    do begin @(negedge clk); p++; end while (!sel(use_fb) && p < 20000);
  endtask

  task automatic period_after_set(input bit use_fb, output int p);
    sync_edge(use_fb);
    count_to_edge(use_fb, p);   // may still use previous ratio
    count_to_edge(use_fb, p);
  endtask

  task automatic t_reset_idle();
    do_reset();
    check("R1 up", up, 0);
    check("R1 dn", dn, 0);
    check("R1 edges", fb_edge | ref_edge, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        seen += fb_edge + ref_edge + up + dn;
      end
      check("R10 no activity without strobes", seen, 0);
    end
  endtask

  task automatic t_main_period();
    int p;
    do_reset();
    vco_en = 1'b1;
    main_ratio = 12'd200;
    period_after_set(1'b1, p);
    check("R2 main 200", p, 800);
    main_ratio = 12'd1000;
    period_after_set(1'b1, p);
    check("R2 main 1000", p, 4000);
    main_ratio = 12'd5;
    period_after_set(1'b1, p);
    check("R3 main clamp low", p, 512);
    main_ratio = 12'd4000;
    period_after_set(1'b1, p);
    check("R3 main clamp high", p, 10400);
  endtask

  task automatic t_ref_period();
    int p;
    do_reset();
    xtal_en = 1'b1;
    ref_ratio = 8'd10;
    period_after_set(1'b0, p);
    check("R4 ref 10", p, 20);
    ref_ratio = 8'd80;
    period_after_set(1'b0, p);
    check("R4 ref 80", p, 160);
    ref_ratio = 8'd1;
    period_after_set(1'b0, p);
    check("R5 ref clamp low 1", p, 4);
    ref_ratio = 8'd0;
    period_after_set(1'b0, p);
    check("R5 ref clamp low 0", p, 4);
    ref_ratio = 8'd255;
    period_after_set(1'b0, p);
    check("R5 ref clamp high", p, 160);
  endtask

  task automatic t_ratio_change();
    int p;
    do_reset();
    vco_en = 1'b1;
    main_ratio = 12'd200;
    period_after_set(1'b1, p);   // ends on an edge
    main_ratio = 12'd300;
    count_to_edge(1'b1, p);
    check("R6 period keeps old ratio", p, 800);
    count_to_edge(1'b1, p);
    check("R6 following period uses new ratio", p, 1200);
  endtask

  task automatic t_up_then_dn();
    int n = 0;
    do_reset();
    xtal_en = 1'b1;
    @(negedge clk);
    xtal_en = 1'b0;
    n = 1;
    while (!up && n < 10) begin @(negedge clk); n++; end
    check("R7 up rises on third cycle after strobe", n, 3);
    check("R7 dn idle", dn, 0);
    repeat (20) @(negedge clk);
    check("R7 up held", up, 1);
    check("R10 dn stays low without feedback strobe", dn, 0);
    vco_en = 1'b1;
    @(negedge clk);
    vco_en = 1'b0;
    check("R7 up held before fb edge", up, 1);
    @(negedge clk);
    check("R7 fb edge seen", fb_edge, 1);
    @(negedge clk);
    check("R8 both high", {31'd0, up & dn}, 1);
    @(negedge clk);
    check("R8 both cleared", {30'd0, up, dn}, 0);
  endtask

  task automatic t_coincident();
    do_reset();
    vco_en = 1'b1; xtal_en = 1'b1;
    @(negedge clk);
    vco_en = 1'b0; xtal_en = 1'b0;
    @(negedge clk);
    check("R9 edges coincide", {30'd0, fb_edge, ref_edge}, 3);
    @(negedge clk);
    check("R9 brief pulse", {30'd0, up, dn}, 3);
    @(negedge clk);
    check("R9 cleared after one cycle", {30'd0, up, dn}, 0);
    repeat (10) @(negedge clk);
    check("R9 stays low", {30'd0, up, dn}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_main_period();
    t_ref_period();
    t_ratio_change();
    t_up_then_dn();
    t_coincident();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule